// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address, separate read and write strobes and 8-bit data. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. Control words set up a channel, take a snapshot of its count, or issue a read-back command that snapshots count and/or status on several channels at once.

Toward the counter engines the block drives, per channel, a one-cycle load strobe with a 16-bit start value, the 3-bit counting mode and the BCD flag. It receives each channel's live 16-bit count, its OUT level and a pulse that reports when the counter has taken a new start value. Counting itself happens outside this block. A read returns data combinationally while the read strobe is high. Its side effects (byte sequencing, clearing latches) commit on the clock edge that ends the read cycle. Writes commit on the clock edge, and a load strobe appears in the cycle after the write that completes a count.

Top module: `tmr_if`

## Requirements
- R1: A control word at address 3 has the channel in bits 7:6 (3 = read-back), the access mode in bits 5:4 (0 latch count, 1 low byte only, 2 high byte only, 3 low then high), the counting mode in bits 3:1 and BCD in bit 0. When the access field is nonzero, it sets that channel's mode and BCD outputs. Mode values 6 and 7 are stored as 2 and 3.
- R2: A control word with a nonzero access field restarts that channel's read and write byte sequencing, so the next data byte is treated as the first byte.
- R3: A data write in low-only mode loads {8'h00, byte}. In high-only mode it loads {byte, 8'h00}. The load strobe of that channel alone is high for one cycle, in the cycle after the write.
- R4: In word mode, the first data byte is held and produces no load. The second byte loads {second, first}.
- R5: A count-latch command captures the live count at the write edge. Later reads return the captured value, even after the live count changes.
- R6: A count-latch command is ignored while the channel still holds an unread latched count.
- R7: A latched count read in word mode returns the low byte, then the high byte, and is then released. After that, reads return the live count.
- R8: In a read-back command, bits 1, 2 and 3 select channels 0, 1 and 2. A low bit 5 latches the count of every selected channel, and a low bit 4 latches its status. Channels that are not selected are unaffected.
- R9: The status byte is {OUT, null count, access[1:0], mode[2:0], BCD}, from bit 7 down to bit 0. A pending status is returned before a latched count, and only once.
- R10: Without a latch, reads return the live count: the low byte in low-only mode, the high byte in high-only mode, and low then high alternately in word mode.
- R11: Reads from address 3 return 0 and leave all channel latches untouched.
- R12: Null count (status bit 6) is set by a control word or a count load, and cleared by the channel's count-taken pulse. When both occur in the same cycle, the set wins.
- R13: After reset every channel is in low-only access, mode 0, BCD 0, with null count clear and no latch pending. No load strobe is high, and read data is 0 when no read is active.
- R14: A status-latch command is ignored while the channel already has an unread status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Port select: 0 to 2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| cnt_load | output | 3 | Per-channel load strobe |
| cnt_load_val | output | 48 | Per-channel start value, channel n at bits 16n+15:16n |
| cnt_mode | output | 9 | Per-channel counting mode, channel n at bits 3n+2:3n |
| cnt_bcd | output | 3 | Per-channel BCD select |
| cnt_live | input | 48 | Per-channel live count, channel n at bits 16n+15:16n |
| cnt_out | input | 3 | Per-channel OUT level |
| cnt_taken | input | 3 | Per-channel pulse: new start value accepted |

## Verification
The collision of interest is between a count write that completes a load and the counter's count-taken pulse on the same channel in the same cycle. One sets null count and the other clears it. The bench drives the second byte of a word write in the same cycle as the taken pulse, then uses a read-back to capture status and expects bit 6 to remain high. A status latch and a count latch from a single read-back command also land together. That case is judged by the read order: status first, then the latched bytes, even though the live count has changed in between.

// File: rtl/tmr_if_pkg.sv
package tmr_if_pkg;
    localparam int NCH    = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;

    typedef struct packed {
        logic              out;
        logic              nul;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } status_t;

    function automatic logic [MODE_W-1:0] norm_mode(input logic [MODE_W-1:0] m);
        return (m > 3'd5) ? (m - 3'd4) : m;
    endfunction
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
    import tmr_if_pkg::*;
(
    input  logic              wr_ctl_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [NCH-1:0]    cw_set_o,
    output logic [NCH-1:0]    cnt_latch_o,
    output logic [NCH-1:0]    st_latch_o,
    output acc_e              acc_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    ctl_word_t cw;
    assign cw     = ctl_word_t'(wdata_i);
    assign acc_o  = cw.acc;
    assign mode_o = norm_mode(cw.mode);
    assign bcd_o  = cw.bcd;

    always_comb begin
        cw_set_o    = '0;
        cnt_latch_o = '0;
        st_latch_o  = '0;
        if (wr_ctl_i) begin
            if (cw.sel == 2'd3) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (wdata_i[ch+1]) begin
                        cnt_latch_o[ch] = !wdata_i[5];
                        st_latch_o[ch]  = !wdata_i[4];
                    end
                end
            end else begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (cw.sel == 2'(ch)) begin
                        if (cw.acc == ACC_LATCH) cnt_latch_o[ch] = 1'b1;
                        else                     cw_set_o[ch]    = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_set_i,
    input  acc_e              cw_acc_i,
    input  logic [MODE_W-1:0] cw_mode_i,
    input  logic              cw_bcd_i,
    input  logic              cnt_latch_i,
    input  logic              st_latch_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  live_i,
    input  logic              out_i,
    input  logic              taken_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    acc_e              acc_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              wr_hi_q, rd_hi_q;
    logic [BYTE_W-1:0] wlat_q;
    acc_e              cl_q;
    logic [CNT_W-1:0]  cl_val_q;
    logic              st_pend_q;
    status_t           st_val_q;
    logic              null_q;
    logic              load_q;
    logic [CNT_W-1:0]  load_val_q;
    logic              load_evt;
    status_t           st_now;

    assign load_evt   = wr_i && ((acc_q != ACC_WORD) || wr_hi_q);
    assign st_now     = '{out: out_i, nul: null_q, acc: acc_q, mode: mode_q, bcd: bcd_q};
    assign load_o     = load_q;
    assign load_val_o = load_val_q;
    assign mode_o     = mode_q;
    assign bcd_o      = bcd_q;

    always_comb begin
        if (st_pend_q)
            rd_byte_o = st_val_q;
        else if (cl_q != ACC_LATCH)
            rd_byte_o = (cl_q == ACC_HI) ? cl_val_q[CNT_W-1:BYTE_W] : cl_val_q[BYTE_W-1:0];
        else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
            rd_byte_o = live_i[CNT_W-1:BYTE_W];
        else
            rd_byte_o = live_i[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= ACC_LO;
            mode_q     <= '0;
            bcd_q      <= 1'b0;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            wlat_q     <= '0;
            cl_q       <= ACC_LATCH;
            cl_val_q   <= '0;
            st_pend_q  <= 1'b0;
            st_val_q   <= '0;
            null_q     <= 1'b0;
            load_q     <= 1'b0;
            load_val_q <= '0;
        end else begin
            load_q <= 1'b0;
            if (rd_i) begin
                if (st_pend_q)
                    st_pend_q <= 1'b0;
                else if (cl_q != ACC_LATCH)
                    cl_q <= (cl_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
                else if (acc_q == ACC_WORD)
                    rd_hi_q <= !rd_hi_q;
            end
            if (cnt_latch_i && cl_q == ACC_LATCH) begin
                cl_val_q <= live_i;
                cl_q     <= acc_q;
            end
            if (st_latch_i && !st_pend_q) begin
                st_val_q  <= st_now;
                st_pend_q <= 1'b1;
            end
            if (cw_set_i) begin
                acc_q   <= cw_acc_i;
                mode_q  <= cw_mode_i;
                bcd_q   <= cw_bcd_i;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
            end
            if (wr_i) begin
                case (acc_q)
                    ACC_HI: begin
                        load_q     <= 1'b1;
                        load_val_q <= {wdata_i, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!wr_hi_q) begin
                            wlat_q  <= wdata_i;
                            wr_hi_q <= 1'b1;
                        end else begin
                            load_q     <= 1'b1;
                            load_val_q <= {wdata_i, wlat_q};
                            wr_hi_q    <= 1'b0;
                        end
                    end
                    default: begin
                        load_q     <= 1'b1;
                        load_val_q <= {{BYTE_W{1'b0}}, wdata_i};
                    end
                endcase
            end
            if (cw_set_i || load_evt)
                null_q <= 1'b1;
            else if (taken_i)
                null_q <= 1'b0;
        end
    end

    // R3
    load_src_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(wr_i));

    // R12
    null_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |-> null_q);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cl_q != ACC_LATCH && cnt_latch_i) |=> $stable(cl_val_q));

    // R14
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_pend_q && !rd_i) |=> (st_pend_q && $stable(st_val_q)));
endmodule

// File: rtl/tmr_if.sv
module tmr_if
    import tmr_if_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    output logic [NCH-1:0]        cnt_load,
    output logic [NCH*CNT_W-1:0]  cnt_load_val,
    output logic [NCH*MODE_W-1:0] cnt_mode,
    output logic [NCH-1:0]        cnt_bcd,
    input  logic [NCH*CNT_W-1:0]  cnt_live,
    input  logic [NCH-1:0]        cnt_out,
    input  logic [NCH-1:0]        cnt_taken
);
    logic              wr_ctl;
    logic [NCH-1:0]    cw_set, cnt_latch, st_latch;
    acc_e              cw_acc;
    logic [MODE_W-1:0] cw_mode;
    logic              cw_bcd;
    logic [BYTE_W-1:0] rd_bytes [NCH];

    assign wr_ctl = bus_wr && (bus_addr == CTL_ADDR);

    tmr_cw_decode u_dec (
        .wr_ctl_i    (wr_ctl),
        .wdata_i     (bus_wdata),
        .cw_set_o    (cw_set),
        .cnt_latch_o (cnt_latch),
        .st_latch_o  (st_latch),
        .acc_o       (cw_acc),
        .mode_o      (cw_mode),
        .bcd_o       (cw_bcd)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        tmr_chan u_chan (
            .clk         (clk),
            .rst         (rst),
            .cw_set_i    (cw_set[ch]),
            .cw_acc_i    (cw_acc),
            .cw_mode_i   (cw_mode),
            .cw_bcd_i    (cw_bcd),
            .cnt_latch_i (cnt_latch[ch]),
            .st_latch_i  (st_latch[ch]),
            .wr_i        (bus_wr && bus_addr == ADDR_W'(ch)),
            .rd_i        (bus_rd && bus_addr == ADDR_W'(ch)),
            .wdata_i     (bus_wdata),
            .live_i      (cnt_live[ch*CNT_W +: CNT_W]),
            .out_i       (cnt_out[ch]),
            .taken_i     (cnt_taken[ch]),
            .rd_byte_o   (rd_bytes[ch]),
            .load_o      (cnt_load[ch]),
            .load_val_o  (cnt_load_val[ch*CNT_W +: CNT_W]),
            .mode_o      (cnt_mode[ch*MODE_W +: MODE_W]),
            .bcd_o       (cnt_bcd[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int ch = 0; ch < NCH; ch++)
                if (bus_addr == ADDR_W'(ch)) bus_rdata = rd_bytes[ch];
        end
    end

    // R11
    rd_ctl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CTL_ADDR) |-> (bus_rdata == '0));

    // R3
    load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_load));
endmodule

// File: tb/sim_tmr_if.sv
`timescale 1ns/1ps
module sim_tmr_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  cnt_load;
    logic [47:0] cnt_load_val;
    logic [8:0]  cnt_mode;
    logic [2:0]  cnt_bcd;
    logic [47:0] cnt_live = '0;
    logic [2:0]  cnt_out = '0;
    logic [2:0]  cnt_taken = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_if u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_load(cnt_load),
        .cnt_load_val(cnt_load_val), .cnt_mode(cnt_mode), .cnt_bcd(cnt_bcd),
        .cnt_live(cnt_live), .cnt_out(cnt_out), .cnt_taken(cnt_taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        cnt_live[ch*16 +: 16] = v;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R13 idle rdata", 32'(bus_rdata), 0);
        chk("R13 load", 32'(cnt_load), 0);
        chk("R13 mode", 32'(cnt_mode), 0);
        chk("R13 bcd", 32'(cnt_bcd), 0);
        set_live(0, 16'h1234);
        wr(3, 8'hE2);
        rd(0, v); chk("R13 reset status", 32'(v), 32'h10);
        rd(0, v); chk("R13 live lsb", 32'(v), 32'h34);
    endtask

    task automatic t_decode;
        wr(3, 8'h7F);
        chk("R1 mode 7 -> 3", 32'(cnt_mode[5:3]), 3);
        chk("R1 bcd", 32'(cnt_bcd[1]), 1);
        wr(3, 8'h9C);
        chk("R1 mode 6 -> 2", 32'(cnt_mode[8:6]), 2);
        chk("R1 bcd ch2", 32'(cnt_bcd[2]), 0);
    endtask

    task automatic t_byte_writes;
        wr(2, 8'hAB);
        chk("R3 lsb strobe", 32'(cnt_load), 32'b100);
        chk("R3 lsb value", 32'(cnt_load_val[47:32]), 32'h00AB);
        @(negedge clk);
        chk("R3 strobe one cycle", 32'(cnt_load), 0);
        wr(3, 8'h20);
        wr(0, 8'h5C);
        chk("R3 msb strobe", 32'(cnt_load), 32'b001);
        chk("R3 msb value", 32'(cnt_load_val[15:0]), 32'h5C00);
    endtask

    task automatic t_word_write;
        wr(1, 8'h11);
        chk("R4 first byte no load", 32'(cnt_load), 0);
        wr(1, 8'h22);
        chk("R4 second byte load", 32'(cnt_load), 32'b010);
        chk("R4 word value", 32'(cnt_load_val[31:16]), 32'h2211);
    endtask

    task automatic t_resequence;
        wr(1, 8'h33);
        wr(3, 8'h7F);
        wr(1, 8'h44);
        chk("R2 restart no load", 32'(cnt_load), 0);
        wr(1, 8'h55);
        chk("R2 restart value", 32'(cnt_load_val[31:16]), 32'h5544);
    endtask

    task automatic t_null;
        logic [7:0] v;
        cnt_out[1] = 1'b1;
        wr(3, 8'hE4);
        rd(1, v); chk("R12 null after load", 32'(v), 32'hF7);
        @(negedge clk); cnt_taken[1] = 1'b1;
        @(negedge clk); cnt_taken[1] = 1'b0;
        wr(3, 8'hE4);
        rd(1, v); chk("R12 null cleared", 32'(v), 32'hB7);
        wr(1, 8'h01);
        @(negedge clk);
        bus_addr = 1; bus_wr = 1'b1; bus_wdata = 8'h02; cnt_taken[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt_taken[1] = 1'b0;
        chk("R4 collision value", 32'(cnt_load_val[31:16]), 32'h0201);
        wr(3, 8'hE4);
        rd(1, v); chk("R12 set wins", 32'(v), 32'hF7);
    endtask

    task automatic t_count_latch;
        logic [7:0] v;
        wr(3, 8'h7F);
        set_live(1, 16'hBEEF);
        wr(3, 8'h40);
        set_live(1, 16'h1111);
        wr(3, 8'h40);
        rd(1, v); chk("R5 latched lsb", 32'(v), 32'hEF);
        rd(1, v); chk("R7 latched msb", 32'(v), 32'hBE);
        set_live(1, 16'h2211);
        rd(1, v); chk("R7 released live lsb", 32'(v), 32'h11);
        rd(1, v); chk("R10 word live msb", 32'(v), 32'h22);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        cnt_out[0] = 1'b0;
        set_live(0, 16'hA5C3);
        wr(3, 8'hC2);
        set_live(0, 16'h0F00);
        rd(0, v); chk("R9 status first", 32'(v), 32'h60);
        rd(0, v); chk("R9 then latched msb", 32'(v), 32'hA5);
        rd(0, v); chk("R10 live msb", 32'(v), 32'h0F);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        set_live(1, 16'h1357);
        set_live(2, 16'h2468);
        wr(3, 8'hDC);
        set_live(0, 16'h7700);
        set_live(1, 16'h0000);
        set_live(2, 16'h0000);
        rd(2, v); chk("R8 ch2 latched", 32'(v), 32'h68);
        rd(1, v); chk("R8 ch1 latched lsb", 32'(v), 32'h57);
        rd(1, v); chk("R8 ch1 latched msb", 32'(v), 32'h13);
        rd(0, v); chk("R8 ch0 unselected live", 32'(v), 32'h77);
        set_live(2, 16'h00C4);
        rd(2, v); chk("R10 ch2 live lsb", 32'(v), 32'hC4);
    endtask

    task automatic t_ctl_read;
        logic [7:0] v;
        cnt_out[0] = 1'b1;
        wr(3, 8'hE2);
        rd(3, v); chk("R11 ctl read zero", 32'(v), 0);
        rd(0, v); chk("R11 status kept", 32'(v), 32'hE0);
    endtask

    task automatic t_status_once;
        logic [7:0] v;
        cnt_out[2] = 1'b0;
        wr(3, 8'hE8);
        cnt_out[2] = 1'b1;
        wr(3, 8'hE8);
        rd(2, v); chk("R14 first status kept", 32'(v), 32'h54);
        set_live(2, 16'h0099);
        rd(2, v); chk("R9 status only once", 32'(v), 32'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_byte_writes();
        t_word_write();
        t_resequence();
        t_null();
        t_count_latch();
        t_priority();
        t_readback();
        t_ctl_read();
        t_status_once();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule